// File: doc/BRIEF.md
# Fixed-Priority Eight-Line Interrupt Controller

This block collects up to eight interrupt lines from peripherals and presents one request line to a processor. Each line is registered, and the block captures a rising edge when that line is unmasked and hardware capture is switched on. A captured edge is kept in a sticky status bit until software clears it. The processor reaches the status, pending, mask, clear, vector and master-control registers through a simple address/data port with a write strobe.

The vector output gives the index of the lowest-numbered pending line, which is also the one with the highest priority, so software can branch without scanning. The request generator raises the request only when there is pending work, the master request enable is on and the processor's interrupt flag is set. It then issues nothing more until the processor returns an acknowledge. A build parameter selects the request style: a level that stays high until acknowledged, or a single-cycle pulse.

Top module: `irqc_top`

## Requirements
- R1: A rising edge on line i sets status bit i only if mask-register bit i is 1. The status bit becomes visible two clock edges after the line is first high at a rising edge. Writing 1 to a mask bit unmasks the line and writing 0 masks it.
- R2: A status bit stays set after its line falls. Writing 1 to bit i of the clear register (address 3) clears status bit i. Writing 0 leaves the bit unchanged.
- R3: When a clear write and a new captured edge hit the same bit in the same cycle, the bit stays set.
- R4: The pending register (address 1) equals status AND mask. Clearing a mask bit hides the line from pending but leaves its status bit unchanged.
- R5: The vector output and register (address 4) hold the index of the lowest-numbered pending bit, with bit 0 highest, and hold all ones when nothing is pending.
- R6: The master register (address 5) bit 6 is the capture enable. While it is 0, no edge sets a status bit.
- R7: A request starts only when at least one line is pending, master register bit 7 (request enable) is 1 and the CPU interrupt flag input is 1. It appears on the request output one clock after those conditions are present at a clock edge.
- R8: After a request starts, no new request starts until the acknowledge input is seen high at a clock edge. If work is still pending and the gates are still open, a new request starts on the following edge.
- R9: In level mode the request stays high until the acknowledge edge and is low after it. In pulse mode the request is high for exactly one cycle.
- R10: Reads return status (address 0), pending (1), mask (2), vector (4) and master (5, with only bits 7 and 6 live). The clear register and unused addresses read 0.
- R11: A register changes only when the write strobe is high at a clock edge.
- R12: After reset, status, pending, mask and master read 0, the vector reads all ones and the request output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | N_SRC | Interrupt lines from peripherals |
| wr_valid_i | input | 1 | Write strobe for the register port |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| cpu_iflag_i | input | 1 | Processor interrupt-flag state |
| cpu_ack_i | input | 1 | Processor acknowledge of the current request |
| irq_o | output | 1 | Interrupt request to the processor |
| vector_o | output | DATA_W | Index of highest-priority pending line, all ones when idle |

## Verification
The bench builds two instances with eight lines and an eight-bit data path and drives both with the same stimulus. One uses the level request style and the other the pulse style, so a single handshake sequence shows how the two request shapes differ during hold-off and after the acknowledge. With eight lines, every vector value from 0 to 7 and the idle all-ones code can be reached, and mask patterns that hide the lowest active line show that priority is taken after masking.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [2:0] {
        REG_STATUS = 3'd0,
        REG_PEND   = 3'd1,
        REG_MASK   = 3'd2,
        REG_CLEAR  = 3'd3,
        REG_VECTOR = 3'd4,
        REG_MASTER = 3'd5
    } irqc_reg_e;

    localparam int MASTER_REQ_BIT = 7;
    localparam int MASTER_CAP_BIT = 6;

    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_WAIT = 1'b1
    } req_state_e;

endpackage

// File: rtl/irqc_detect.sv
module irqc_detect #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic [N_SRC-1:0] mask_i,
    input  logic             cap_en_i,
    output logic [N_SRC-1:0] set_o
);

    typedef struct packed {
        logic [N_SRC-1:0] samp;
        logic [N_SRC-1:0] prev;
    } det_t;

    det_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.samp = src_i;
        state_d.prev = state_q.samp;
        set_o        = state_q.samp & ~state_q.prev & mask_i & {N_SRC{cap_en_i}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R1: a captured edge marks one cycle only, never two in a row
    a_r1_single_cycle_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_o & $past(set_o)) == '0));

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [N_SRC-1:0]  set_i,
    output logic [N_SRC-1:0]  mask_o,
    output logic [N_SRC-1:0]  pend_o,
    output logic              req_en_o,
    output logic              cap_en_o,
    output logic [DATA_W-1:0] vec_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    typedef struct packed {
        logic [N_SRC-1:0] status;
        logic [N_SRC-1:0] mask;
        logic             req_en;
        logic             cap_en;
    } regs_t;

    regs_t            state_d, state_q;
    logic [N_SRC-1:0] clr_vec;
    logic             sel_mask, sel_clear, sel_master;

    always_comb begin
        sel_mask   = wr_i && (addr_i == ADDR_W'(REG_MASK));
        sel_clear  = wr_i && (addr_i == ADDR_W'(REG_CLEAR));
        sel_master = wr_i && (addr_i == ADDR_W'(REG_MASTER));
        clr_vec    = sel_clear ? wdata_i[N_SRC-1:0] : '0;

        state_d        = state_q;
        state_d.status = (state_q.status & ~clr_vec) | set_i;
        if (sel_mask) begin
            state_d.mask = wdata_i[N_SRC-1:0];
        end
        if (sel_master) begin
            state_d.req_en = wdata_i[MASTER_REQ_BIT];
            state_d.cap_en = wdata_i[MASTER_CAP_BIT];
        end
    end

    always_comb begin
        pend_o = state_q.status & state_q.mask;
        vec_o  = '1;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend_o[i]) begin
                vec_o = DATA_W'(i);
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(REG_STATUS): rdata_o = DATA_W'(state_q.status);
            ADDR_W'(REG_PEND):   rdata_o = DATA_W'(pend_o);
            ADDR_W'(REG_MASK):   rdata_o = DATA_W'(state_q.mask);
            ADDR_W'(REG_VECTOR): rdata_o = vec_o;
            ADDR_W'(REG_MASTER): begin
                rdata_o[MASTER_REQ_BIT] = state_q.req_en;
                rdata_o[MASTER_CAP_BIT] = state_q.cap_en;
            end
            default:             rdata_o = '0;
        endcase
    end

    assign mask_o   = state_q.mask;
    assign req_en_o = state_q.req_en;
    assign cap_en_o = state_q.cap_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R1: a status bit can only rise for a line that was unmasked
    a_r1_capture_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        (((state_q.status & ~$past(state_q.status)) & ~$past(state_q.mask)) == '0));

    // R2: a status bit only falls after a clear write naming it
    a_r2_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(state_q.status) & ~$past(clr_vec)) & ~state_q.status) == '0));

    // R5: the vector names a pending bit with no lower pending bit
    a_r5_vector_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_o != '1) |-> (pend_o[vec_o[IDX_W-1:0]] &&
            ((pend_o & ((N_SRC'(1) << vec_o[IDX_W-1:0]) - N_SRC'(1))) == '0)));

    // R5: all ones means nothing is pending
    a_r5_vector_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_o == '1) |-> (pend_o == '0));

endmodule

// File: rtl/irqc_reqgen.sv
module irqc_reqgen
    import irqc_pkg::*;
#(
    parameter bit IRQ_PULSE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_any_i,
    input  logic req_en_i,
    input  logic iflag_i,
    input  logic ack_i,
    output logic irq_o
);

    typedef struct packed {
        req_state_e st;
        logic       irq;
    } req_t;

    req_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        case (state_q.st)
            REQ_IDLE: if (pend_any_i && req_en_i && iflag_i) state_d.st = REQ_WAIT;
            REQ_WAIT: if (ack_i) state_d.st = REQ_IDLE;
            default:  state_d.st = REQ_IDLE;
        endcase
        if (IRQ_PULSE) begin
            state_d.irq = (state_q.st == REQ_IDLE) && (state_d.st == REQ_WAIT);
        end else begin
            state_d.irq = (state_d.st == REQ_WAIT);
        end
    end

    assign irq_o = state_q.irq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{st: REQ_IDLE, irq: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    // R7: a request only starts with work pending and both gates open
    a_r7_issue_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st == REQ_WAIT && $past(state_q.st) == REQ_IDLE)
            |-> $past(pend_any_i && req_en_i && iflag_i));

    // R8: without an acknowledge the controller keeps waiting
    a_r8_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st == REQ_WAIT && !ack_i) |=> (state_q.st == REQ_WAIT));

    generate
        if (IRQ_PULSE) begin : g_pulse
            // R9: pulse style lasts one cycle
            a_r9_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
                irq_o |=> !irq_o);
        end else begin : g_level
            // R9: level style holds until acknowledged
            a_r9_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_o && !ack_i) |=> irq_o);
        end
    endgenerate

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int N_SRC     = 8,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 3,
    parameter bit IRQ_PULSE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_src_i,
    input  logic              wr_valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              cpu_iflag_i,
    input  logic              cpu_ack_i,
    output logic              irq_o,
    output logic [DATA_W-1:0] vector_o
);

    logic [N_SRC-1:0] set_vec;
    logic [N_SRC-1:0] mask_vec;
    logic [N_SRC-1:0] pend_vec;
    logic             req_en;
    logic             cap_en;

    irqc_detect #(.N_SRC(N_SRC)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (irq_src_i),
        .mask_i   (mask_vec),
        .cap_en_i (cap_en),
        .set_o    (set_vec)
    );

    irqc_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_valid_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .set_i    (set_vec),
        .mask_o   (mask_vec),
        .pend_o   (pend_vec),
        .req_en_o (req_en),
        .cap_en_o (cap_en),
        .vec_o    (vector_o),
        .rdata_o  (rdata_o)
    );

    irqc_reqgen #(.IRQ_PULSE(IRQ_PULSE)) u_reqgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_any_i (|pend_vec),
        .req_en_i   (req_en),
        .iflag_i    (cpu_iflag_i),
        .ack_i      (cpu_ack_i),
        .irq_o      (irq_o)
    );

endmodule

// File: tb/sim_irqc_top.sv
module sim_irqc_top;

    localparam int CLK_PERIOD = 10;
    localparam int NTAB = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src = '0;
    logic       wr = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       iflag = 1'b0;
    logic       ack = 1'b0;
    logic [7:0] rdata0, rdata1, vec0, vec1;
    logic       irq0, irq1;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irqc_top #(.IRQ_PULSE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_src_i(src), .wr_valid_i(wr), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata0), .cpu_iflag_i(iflag), .cpu_ack_i(ack),
        .irq_o(irq0), .vector_o(vec0)
    );

    irqc_top #(.IRQ_PULSE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .irq_src_i(src), .wr_valid_i(wr), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata1), .cpu_iflag_i(iflag), .cpu_ack_i(ack),
        .irq_o(irq1), .vector_o(vec1)
    );

    // {mask, lines, expected vector, expected pending}
    localparam logic [31:0] TAB [NTAB] = '{
        {8'hFF, 8'h01, 8'h00, 8'h01},
        {8'hFF, 8'h80, 8'h07, 8'h80},
        {8'hFF, 8'hA4, 8'h02, 8'hA4},
        {8'hF0, 8'h0F, 8'hFF, 8'h00},
        {8'hFE, 8'h03, 8'h01, 8'h02},
        {8'h0F, 8'hF8, 8'h03, 8'h08},
        {8'hFF, 8'h60, 8'h05, 8'h60},
        {8'h55, 8'hFF, 8'h00, 8'h55}
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
        #1;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata0;
    endtask

    task automatic pulse_src(input logic [7:0] pat);
        @(negedge clk); src = pat;
        @(negedge clk);
        @(negedge clk); src = '0;
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] m;
        logic [7:0] p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R12: reset state
        rd_reg(3'd0, v); check("R12 status", v, 8'h00);
        rd_reg(3'd1, v); check("R12 pending", v, 8'h00);
        rd_reg(3'd2, v); check("R12 mask", v, 8'h00);
        rd_reg(3'd5, v); check("R12 master", v, 8'h00);
        rd_reg(3'd4, v); check("R12 vector reg", v, 8'hFF);
        check("R12 irq", {7'd0, irq0}, 8'h00);

        wr_reg(3'd5, 8'h40);

        // R1 R4 R5: table of mask/line patterns
        for (int i = 0; i < NTAB; i++) begin
            m = TAB[i][31:24];
            p = TAB[i][23:16];
            wr_reg(3'd3, 8'hFF);
            wr_reg(3'd2, m);
            pulse_src(p);
            rd_reg(3'd0, v); check($sformatf("R1 status row %0d", i), v, m & p);
            rd_reg(3'd1, v); check($sformatf("R4 pending row %0d", i), v, TAB[i][7:0]);
            rd_reg(3'd4, v); check($sformatf("R5 vector reg row %0d", i), v, TAB[i][15:8]);
            check($sformatf("R5 vector out row %0d", i), vec0, TAB[i][15:8]);
        end

        // R6: capture disabled
        wr_reg(3'd3, 8'hFF);
        wr_reg(3'd2, 8'hFF);
        wr_reg(3'd5, 8'h00);
        pulse_src(8'h01);
        rd_reg(3'd0, v); check("R6 no capture", v, 8'h00);
        wr_reg(3'd5, 8'h40);

        // R11: no write without strobe
        @(negedge clk); addr = 3'd2; wdata = 8'h00; wr = 1'b0;
        step();
        rd_reg(3'd2, v); check("R11 mask kept", v, 8'hFF);

        // R2: sticky, clear by 1, 0 does nothing
        pulse_src(8'h05);
        rd_reg(3'd0, v); check("R2 sticky", v, 8'h05);
        wr_reg(3'd3, 8'h00);
        rd_reg(3'd0, v); check("R2 zero write", v, 8'h05);
        wr_reg(3'd3, 8'h01);
        rd_reg(3'd0, v); check("R2 clear bit0", v, 8'h04);

        // R4: masking hides pending, keeps status
        wr_reg(3'd2, 8'hFB);
        rd_reg(3'd0, v); check("R4 status kept", v, 8'h04);
        rd_reg(3'd1, v); check("R4 pending hidden", v, 8'h00);
        check("R5 idle vector", vec0, 8'hFF);
        wr_reg(3'd2, 8'hFF);

        // R3: clear and new edge in the same cycle
        @(negedge clk); src = 8'h04;
        @(negedge clk); wr = 1'b1; addr = 3'd3; wdata = 8'h04;
        @(negedge clk); wr = 1'b0; src = 8'h00;
        #1;
        rd_reg(3'd0, v); check("R3 set wins", v, 8'h04);
        wr_reg(3'd3, 8'h04);
        rd_reg(3'd0, v); check("R3 later clear", v, 8'h00);

        // R10: read map
        rd_reg(3'd3, v); check("R10 clear reads 0", v, 8'h00);
        wr_reg(3'd5, 8'hFF);
        rd_reg(3'd5, v); check("R10 master bits", v, 8'hC0);
        rd_reg(3'd6, v); check("R10 unused addr", v, 8'h00);
        wr_reg(3'd5, 8'h40);

        // R7: gating of the request
        wr_reg(3'd3, 8'hFF);
        pulse_src(8'h02);
        wr_reg(3'd5, 8'hC0);
        step(); step();
        check("R7 no flag", {irq1, irq0}, 8'h00);
        wr_reg(3'd5, 8'h40);
        @(negedge clk); iflag = 1'b1;
        step(); step();
        check("R7 no master", {irq1, irq0}, 8'h00);
        wr_reg(3'd5, 8'hC0);
        check("R7 not yet", {irq1, irq0}, 8'h00);
        step();
        check("R7 issued level", {7'd0, irq0}, 8'h01);
        check("R9 issued pulse", {7'd0, irq1}, 8'h01);
        step();
        check("R9 level held", {7'd0, irq0}, 8'h01);
        check("R9 pulse dropped", {7'd0, irq1}, 8'h00);
        step(); step();
        check("R8 hold off", {irq1, irq0}, 8'h01);

        // R8 R9: acknowledge and re-request
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        #1;
        check("R9 level released", {7'd0, irq0}, 8'h00);
        check("R8 pulse low at ack", {7'd0, irq1}, 8'h00);
        step();
        check("R8 re-request level", {7'd0, irq0}, 8'h01);
        check("R8 re-request pulse", {7'd0, irq1}, 8'h01);

        // R7 R8: flag low after ack stops requests
        @(negedge clk); iflag = 1'b0; ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        #1;
        step();
        check("R7 flag low no request", {irq1, irq0}, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule